// File: doc/BRIEF.md
# ADC Power and Reference Sequencer

This block decides when a converter's internal voltage reference and its conversion core receive power. It watches three events from the serial-bus front end: a strobe that carries the two power-mode bits from a freshly received command byte, a strobe that marks a bus STOP or repeated START, and a pulse that marks the end of a conversion. From these it drives an enable for the reference and an enable for the converter core. Each enable has a matching ready flag, which rises only after a settling or wake-up interval has been counted out.

The reference does not react to a request to turn on at once. The command only arms the request, and the switch happens at the next bus boundary, which keeps the reference from switching in the middle of a transfer. Turning the reference off, by contrast, takes effect as soon as the command arrives. The core wakes up on every command. After a conversion it stays awake or goes back to sleep according to the low mode bit of the latest command. The reference settling interval comes from an input count, so firmware-level logic can size it to the reference capacitor, with about 70,000 cycles at 50 MHz for a 1.4 ms wait. The core wake-up interval is a fixed parameter.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, ref_en, ref_ready, adc_pwr_en and adc_ready are all 0, so the reference starts off.
- R2: Mode bit 1 (cmd_pd[1]) requests the reference. A command with cmd_pd[1]=1 while the reference is off leaves ref_en at 0. ref_en rises at the clock edge that samples the next bus_evt pulse.
- R3: A request that is armed but not yet applied is dropped when a command with cmd_pd[1]=0 arrives before the bus event. The bus event then leaves ref_en at 0.
- R4: While ref_en is 1, a command with cmd_pd[1]=1 keeps ref_en at 1 and does not restart settling, so ref_ready stays 1.
- R5: While ref_en is 1, a command with cmd_pd[1]=0 clears ref_en and ref_ready at the edge that samples the command.
- R6: ref_ready rises exactly N clock edges after the edge on which ref_en rises. N is the value of settle_cycles at turn-on, and N=0 makes both rise together.
- R7: A bus_evt with no armed request leaves ref_en unchanged.
- R8: Every command sets adc_pwr_en at the edge that samples it. When the core was off, adc_ready rises PWRUP_CYCLES edges after adc_pwr_en does.
- R9: Mode bit 0 (cmd_pd[0]) holds the core. On conv_done, the core stays powered if the latest command had cmd_pd[0]=1. Otherwise adc_pwr_en and adc_ready clear at the next edge.
- R10: A command that arrives while the core is already powered does not restart the wake-up count, so adc_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: a command byte has been received |
| cmd_pd | input | 2 | Power-mode bits of that command: [1] reference, [0] core hold |
| bus_evt | input | 1 | One-cycle strobe on bus STOP or repeated START |
| conv_done | input | 1 | One-cycle pulse at the end of a conversion |
| settle_cycles | input | SETTLE_W | Reference settling interval in clock cycles |
| ref_en | output | 1 | Internal reference enable |
| ref_ready | output | 1 | Reference enabled and settled |
| adc_pwr_en | output | 1 | Converter core power enable |
| adc_ready | output | 1 | Core powered and wake-up interval elapsed |

## Verification
A lost or stale arm bit shows up at the ports only at the next bus event, as ref_en failing to rise or rising when it should not. The tests therefore always follow a command with a bus_evt pulse and sample ref_en one cycle later. A wrong settling or wake-up count shifts the rising edge of a ready flag by one or more cycles, so the ready flags are sampled both in the cycle before the expected rise and in the cycle of the rise. A wrong hold bit for the core shows up only after the next conv_done, which is why conversions are ended under both values of mode bit 0.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  // Mode field of a command: bit 1 requests the reference, bit 0 holds the core.
  typedef struct packed {
    logic ref_req;
    logic core_hold;
  } pd_mode_t;

  function automatic pd_mode_t decode_pd(input logic [1:0] pd);
    pd_mode_t m;
    m.ref_req   = pd[1];
    m.core_hold = pd[0];
    return m;
  endfunction

  function automatic logic core_sleeps(input logic hold, input logic done);
    return done & ~hold;
  endfunction

endpackage

// File: rtl/pwr_delay_timer.sv
module pwr_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         en,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return (v == '0) ? v : v - W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (start)   cnt <= load_val;
    else if (!en)     cnt <= '0;
    else              cnt <= step_down(cnt);
  end

  assign done = en & (cnt == '0);

  // R6 / R8: a start loads the requested interval
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(load_val)));

  // R6 / R8: count falls by one per enabled cycle
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/ref_ctrl.sv
module ref_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic want_ref,
  input  logic bus_evt,
  output logic ref_en,
  output logic ref_start
);

  logic armed;
  logic turn_on;
  logic eff_on;

  assign turn_on   = bus_evt & armed & ~ref_en;
  assign eff_on    = ref_en | turn_on;
  // a command sampled together with the bus event is treated as following it
  assign ref_start = turn_on & ~(cmd_valid & ~want_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_en <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (turn_on) begin
        ref_en <= 1'b1;
        armed  <= 1'b0;
      end
      if (cmd_valid) begin
        if (eff_on) begin
          ref_en <= want_ref;
          armed  <= 1'b0;
        end else begin
          armed  <= want_ref;
        end
      end
    end
  end

  // R2: the reference only switches on at a bus boundary
  p_on_at_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> $past(bus_evt));

  // R4: a keep command never drops the reference
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en && cmd_valid && want_ref) |=> ref_en);

  // R5: an off command takes effect at once
  p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en && cmd_valid && !want_ref) |=> !ref_en);

  // R7: without an armed request a bus event changes nothing
  p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_evt && !armed && !cmd_valid) |=> (ref_en == $past(ref_en)));

endmodule

// File: rtl/core_ctrl.sv
module core_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic hold_bit,
  input  logic conv_done,
  output logic adc_pwr_en,
  output logic core_start
);
  import adc_pwr_pkg::*;

  logic keep_on;

  assign core_start = cmd_valid & ~adc_pwr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_pwr_en <= 1'b0;
      keep_on    <= 1'b0;
    end else if (cmd_valid) begin
      adc_pwr_en <= 1'b1;
      keep_on    <= hold_bit;
    end else if (core_sleeps(keep_on, conv_done)) begin
      adc_pwr_en <= 1'b0;
    end
  end

  // R8: any command wakes the core
  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> adc_pwr_en);

  // R9: end of conversion without hold puts the core to sleep
  p_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cmd_valid && !keep_on) |=> !adc_pwr_en);

  // R9: with hold the core stays up
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_pwr_en && keep_on && !cmd_valid) |=> adc_pwr_en);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int SETTLE_W     = 17,
  parameter int PWRUP_CYCLES = 70
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_pd,
  input  logic                bus_evt,
  input  logic                conv_done,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                ref_en,
  output logic                ref_ready,
  output logic                adc_pwr_en,
  output logic                adc_ready
);
  import adc_pwr_pkg::*;

  localparam int PW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [PW-1:0] PWR_LOAD = PW'(PWRUP_CYCLES);

  pd_mode_t mode;
  logic     ref_start;
  logic     core_start;

  assign mode = decode_pd(cmd_pd);

  ref_ctrl u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .want_ref  (mode.ref_req),
    .bus_evt   (bus_evt),
    .ref_en    (ref_en),
    .ref_start (ref_start)
  );

  pwr_delay_timer #(.W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ref_start),
    .en       (ref_en),
    .load_val (settle_cycles),
    .done     (ref_ready)
  );

  core_ctrl u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .hold_bit   (mode.core_hold),
    .conv_done  (conv_done),
    .adc_pwr_en (adc_pwr_en),
    .core_start (core_start)
  );

  pwr_delay_timer #(.W(PW)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (core_start),
    .en       (adc_pwr_en),
    .load_val (PWR_LOAD),
    .done     (adc_ready)
  );

  // R1: everything off in the first cycle after reset
  p_reset_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!ref_en && !adc_pwr_en));

  // R4: a keep command does not disturb a settled reference
  p_ready_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ready && cmd_valid && mode.ref_req) |=> ref_ready);

  // R10: a command to a running core keeps it ready
  p_no_rewake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ready && cmd_valid) |=> adc_ready);

endmodule

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb;

  localparam int SW  = 17;
  localparam int PWR = 70;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_pd = 2'b00;
  logic          bus_evt = 1'b0;
  logic          conv_done = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic          ref_en, ref_ready, adc_pwr_en, adc_ready;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  adc_pwr_seq #(.SETTLE_W(SW), .PWRUP_CYCLES(PWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pd(cmd_pd),
    .bus_evt(bus_evt), .conv_done(conv_done), .settle_cycles(settle_cycles),
    .ref_en(ref_en), .ref_ready(ref_ready),
    .adc_pwr_en(adc_pwr_en), .adc_ready(adc_ready)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] pd);
    @(negedge clk); cmd_valid = 1'b1; cmd_pd = pd;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic pulse_bus();
    @(negedge clk); bus_evt = 1'b1;
    @(negedge clk); bus_evt = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ref_en, 1'b0, "R1 ref_en");
    chk(ref_ready, 1'b0, "R1 ref_ready");
    chk(adc_pwr_en, 1'b0, "R1 adc_pwr_en");
    chk(adc_ready, 1'b0, "R1 adc_ready");
  endtask

  task automatic t_arm_and_settle();
    settle_cycles = SW'(5);
    send_cmd(2'b10);
    chk(ref_en, 1'b0, "R2 not on at command");
    idle(3);
    chk(ref_en, 1'b0, "R2 still off before bus event");
    pulse_bus();
    chk(ref_en, 1'b1, "R2 on after bus event");
    chk(ref_ready, 1'b0, "R6 not ready at turn-on");
    idle(4);
    chk(ref_ready, 1'b0, "R6 not ready one cycle early");
    idle(1);
    chk(ref_ready, 1'b1, "R6 ready after N cycles");
  endtask

  task automatic t_keep();
    send_cmd(2'b11);
    chk(ref_en, 1'b1, "R4 ref kept");
    chk(ref_ready, 1'b1, "R4 ready kept");
    idle(2);
    chk(ref_ready, 1'b1, "R4 no re-settle");
  endtask

  task automatic t_off();
    send_cmd(2'b01);
    chk(ref_en, 1'b0, "R5 ref off");
    chk(ref_ready, 1'b0, "R5 ready off");
  endtask

  task automatic t_cancel_and_idle_bus();
    send_cmd(2'b10);
    send_cmd(2'b00);
    pulse_bus();
    chk(ref_en, 1'b0, "R3 cancelled request");
    pulse_bus();
    chk(ref_en, 1'b0, "R7 idle bus event");
  endtask

  task automatic t_core();
    pulse_done();
    chk(adc_pwr_en, 1'b0, "R9 sleep after conversion");
    chk(adc_ready, 1'b0, "R9 ready cleared");
    send_cmd(2'b00);
    chk(adc_pwr_en, 1'b1, "R8 wake on command");
    chk(adc_ready, 1'b0, "R8 not ready at wake");
    idle(PWR - 1);
    chk(adc_ready, 1'b0, "R8 not ready one cycle early");
    idle(1);
    chk(adc_ready, 1'b1, "R8 ready after wake-up");
    send_cmd(2'b01);
    chk(adc_ready, 1'b1, "R10 no restart of wake-up");
    pulse_done();
    chk(adc_pwr_en, 1'b1, "R9 held on");
    chk(adc_ready, 1'b1, "R9 still ready when held");
    send_cmd(2'b00);
    pulse_done();
    chk(adc_pwr_en, 1'b0, "R9 sleep without hold");
  endtask

  task automatic t_zero_settle();
    settle_cycles = '0;
    send_cmd(2'b11);
    pulse_bus();
    chk(ref_en, 1'b1, "R6 on with zero settle");
    chk(ref_ready, 1'b1, "R6 ready together with enable");
    send_cmd(2'b00);
    chk(ref_ready, 1'b0, "R5 ready drops on off");
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm_and_settle();
    t_keep();
    t_off();
    t_cancel_and_idle_bus();
    t_core();
    t_zero_settle();
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule